// File: doc/BRIEF.md
# Banked Local Memory Crossbar

This block is the data-side memory of a lockstep array of four compute cores. It holds four single-port synchronous RAM banks. A full crossbar lets each core's single load/store port reach any bank. Every request carries a word address and an array base offset. The block adds the two, then splits the sum into a bank index and a row. The split follows one of two placements, chosen at run time: interleaved (word-striped across banks) or sequential (one contiguous block per bank).

Cores whose requests fall in different banks are all served in the same cycle. When several cores hit one bank, a fixed-priority arbiter serves them one per cycle, lowest core index first. A global stall stays high until the last access of the group has been served, so that all cores advance together. Read data comes back one cycle after its grant and is then held. A free-running count of stall cycles is exposed so that the conflict cost of an access pattern can be measured.

Top module: `bank_xbar`

## Requirements
- R1: After reset, stall_o is 0, stall_cnt_o is 0, every rvalid_o bit is 0 and every rdata_o word is 0.
- R2: With mode_i = 0 (interleaved), the effective address e = (base + addr) mod 256 selects bank e mod 4 and row e / 4.
- R3: With mode_i = 1 (sequential), bank = e[7:6] and row = e[5:0], so each bank holds 64 consecutive words.
- R4: The base offset is added before the bank is selected, so an array with base 3 places its element 0 in bank 3 under interleaving.
- R5: Requests from active cores that target pairwise distinct banks all complete in one cycle, with stall_o low.
- R6: When k active cores target one bank, they are granted one per cycle in ascending core index, so the group takes k cycles in total.
- R7: stall_o is high in every cycle in which an active request is still unserved after this cycle's grants, and low otherwise. Cores hold their requests while it is high.
- R8: A read granted in cycle t raises that core's rvalid_o for cycle t+1 only, with the bank word on rdata_o. rdata_o then holds that value until the core's next read grant.
- R9: A write (we = 1) updates the bank at its grant and produces no rvalid_o pulse. A later grant to the same bank sees the new value.
- R10: stall_cnt_o increases by one after every cycle with stall_o high and holds otherwise, wrapping modulo 2^16.
- R11: Under interleaving, a stride-2 pattern from four cores (addresses 0, 2, 4, 6) uses only two banks and costs exactly one stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Placement: 0 interleaved, 1 sequential; change only when idle |
| req_i | input | 4 | Per-core request valid |
| we_i | input | 4 | Per-core write enable |
| addr_i | input | 32 | Per-core word address, 8 bits per core, core 0 in bits 7:0 |
| base_i | input | 32 | Per-core array base offset, 8 bits per core |
| wdata_i | input | 64 | Per-core write data, 16 bits per core |
| rvalid_o | output | 4 | Per-core read data valid, one cycle after the grant |
| rdata_o | output | 64 | Per-core read data, held between reads |
| stall_o | output | 1 | Global lockstep stall |
| stall_cnt_o | output | 16 | Count of stalled cycles |

## Verification
A corrupted served mask appears at once as a group length that differs from the largest per-bank conflict count. It also shows as an rvalid_o pulse in the wrong cycle for a core, both visible within the same access group. A wrong bank or row split appears on the first read that crosses placements or offsets: data written through one mapping is read through another, so the wrong word shows on rdata_o one cycle after the grant. Loss of the read-hold register shows as rdata_o changing on idle or write-only cycles that follow a read.

// File: rtl/bank_xbar_pkg.sv
package bank_xbar_pkg;
  typedef enum logic {
    MAP_ILV = 1'b0,
    MAP_SEQ = 1'b1
  } map_mode_e;
endpackage

// File: rtl/bank_xbar_amap.sv
module bank_xbar_amap #(
  parameter int AW = 8,
  parameter int BW = 2,
  localparam int RW = AW - BW
) (
  input  logic          mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] addr_i,
  output logic [BW-1:0] bank_o,
  output logic [RW-1:0] row_o
);
  import bank_xbar_pkg::*;
  logic [AW-1:0] eff;

  assign eff = base_i + addr_i;

  always_comb begin
    if (map_mode_e'(mode_i) == MAP_SEQ) begin
      bank_o = eff[AW-1:RW];
      row_o  = eff[RW-1:0];
    end else begin
      bank_o = eff[BW-1:0];
      row_o  = eff[AW-1:BW];
    end
  end
endmodule

// File: rtl/bank_xbar_arb.sv
module bank_xbar_arb #(
  parameter int NC = 4
) (
  input  logic [NC-1:0] hit_i,
  output logic [NC-1:0] gnt_o
);
  logic taken;
  // lowest index wins
  always_comb begin
    gnt_o = '0;
    taken = 1'b0;
    for (int i = 0; i < NC; i++) begin
      if (hit_i[i] && !taken) begin
        gnt_o[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_xbar_ram.sv
module bank_xbar_ram #(
  parameter int RW = 6,
  parameter int DW = 16,
  localparam int DEPTH = 2 ** RW
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [RW-1:0] row_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[row_i] <= wdata_i;
      else      rdata_o    <= mem[row_i];
    end
  end
endmodule

// File: rtl/bank_xbar.sv
module bank_xbar #(
  parameter int NC = 4,
  parameter int NB = 4,
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int BW = $clog2(NB),
  localparam int RW = AW - BW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [NC-1:0]    req_i,
  input  logic [NC-1:0]    we_i,
  input  logic [NC*AW-1:0] addr_i,
  input  logic [NC*AW-1:0] base_i,
  input  logic [NC*DW-1:0] wdata_i,
  output logic [NC-1:0]    rvalid_o,
  output logic [NC*DW-1:0] rdata_o,
  output logic             stall_o,
  output logic [CW-1:0]    stall_cnt_o
);
  logic [NC-1:0]    served_q, pend, gnt;
  logic [NC*BW-1:0] bank_flat;
  logic [NC*RW-1:0] row_flat;
  logic [NB*NC-1:0] bgnt_flat;
  logic [NB*DW-1:0] bdout_flat;
  logic [NC-1:0]    rd_q;

  assign pend = req_i & ~served_q;

  for (genvar c = 0; c < NC; c++) begin : g_map
    bank_xbar_amap #(.AW(AW), .BW(BW)) amap_i (
      .mode_i (mode_i),
      .base_i (base_i[c*AW +: AW]),
      .addr_i (addr_i[c*AW +: AW]),
      .bank_o (bank_flat[c*BW +: BW]),
      .row_o  (row_flat[c*RW +: RW])
    );
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [NC-1:0] hit;
    logic          en, we;
    logic [RW-1:0] row;
    logic [DW-1:0] wd;

    always_comb begin
      for (int c = 0; c < NC; c++)
        hit[c] = pend[c] && (bank_flat[c*BW +: BW] == BW'(b));
    end

    bank_xbar_arb #(.NC(NC)) arb_i (
      .hit_i (hit),
      .gnt_o (bgnt_flat[b*NC +: NC])
    );

    // crossbar: steer the granted core onto this bank
    always_comb begin
      en  = |bgnt_flat[b*NC +: NC];
      we  = 1'b0;
      row = '0;
      wd  = '0;
      for (int c = 0; c < NC; c++) begin
        if (bgnt_flat[b*NC + c]) begin
          we  = we_i[c];
          row = row_flat[c*RW +: RW];
          wd  = wdata_i[c*DW +: DW];
        end
      end
    end

    bank_xbar_ram #(.RW(RW), .DW(DW)) ram_i (
      .clk_i   (clk_i),
      .en_i    (en),
      .we_i    (we),
      .row_i   (row),
      .wdata_i (wd),
      .rdata_o (bdout_flat[b*DW +: DW])
    );
  end

  always_comb begin
    gnt = '0;
    for (int b = 0; b < NB; b++) gnt = gnt | bgnt_flat[b*NC +: NC];
  end

  assign stall_o = |(pend & ~gnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      served_q    <= '0;
      stall_cnt_o <= '0;
    end else begin
      served_q <= stall_o ? (served_q | gnt) : '0;
      if (stall_o) stall_cnt_o <= stall_cnt_o + 1'b1;
    end
  end

  // return path: bank output is live for one cycle, then held per core
  for (genvar c = 0; c < NC; c++) begin : g_ret
    logic [BW-1:0] bank_q;
    logic [DW-1:0] hold_q, live;

    assign live = bdout_flat[bank_q*DW +: DW];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q[c] <= 1'b0;
        bank_q  <= '0;
        hold_q  <= '0;
      end else begin
        rd_q[c] <= gnt[c] & ~we_i[c];
        bank_q  <= bank_flat[c*BW +: BW];
        if (rd_q[c]) hold_q <= live;
      end
    end

    assign rdata_o[c*DW +: DW] = rd_q[c] ? live : hold_q;
  end

  assign rvalid_o = rd_q;
endmodule

// File: rtl/bank_xbar_chk.sv
module bank_xbar_chk #(
  parameter int NC = 4,
  parameter int NB = 4,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int BW = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NC-1:0]    req_i,
  input logic [NC-1:0]    we_i,
  input logic [NC-1:0]    rvalid_o,
  input logic [NC*DW-1:0] rdata_o,
  input logic             stall_o,
  input logic [CW-1:0]    stall_cnt_o,
  input logic [NC-1:0]    gnt,
  input logic [NC*BW-1:0] bank_flat
);
  for (genvar b = 0; b < NB; b++) begin : g_b
    logic [NC-1:0] m;
    always_comb begin
      for (int c = 0; c < NC; c++) m[c] = gnt[c] && (bank_flat[c*BW +: BW] == BW'(b));
    end
    AST_BANK_ONE_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(m)); // R6
  end

  for (genvar c = 0; c < NC; c++) begin : g_c
    AST_RD_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt[c] && !we_i[c] |=> rvalid_o[c]); // R8
    AST_WR_NO_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt[c] && we_i[c] |=> !rvalid_o[c]); // R9
    AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rvalid_o[c] |-> $stable(rdata_o[c*DW +: DW])); // R8
  end

  AST_IDLE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |-> !stall_o); // R7
  AST_REQ_PROGRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt)); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> stall_cnt_o == $past(stall_cnt_o) + 1'b1); // R10
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |=> $stable(stall_cnt_o)); // R10
endmodule

bind bank_xbar bank_xbar_chk #(.NC(NC), .NB(NB), .DW(DW), .CW(CW), .BW(BW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .rvalid_o    (rvalid_o),
  .rdata_o     (rdata_o),
  .stall_o     (stall_o),
  .stall_cnt_o (stall_cnt_o),
  .gnt         (gnt),
  .bank_flat   (bank_flat)
);

// File: tb/bank_xbar_tb_top.sv
module bank_xbar_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4, AW = 8, DW = 16, CW = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             mode_i = 1'b0;
  logic [NC-1:0]    req_i = '0, we_i = '0;
  logic [NC*AW-1:0] addr_i = '0, base_i = '0;
  logic [NC*DW-1:0] wdata_i = '0;
  logic [NC-1:0]    rvalid_o;
  logic [NC*DW-1:0] rdata_o;
  logic             stall_o;
  logic [CW-1:0]    stall_cnt_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [256];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bank_xbar dut_i (.*);

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int phys(int mode, int base, int addr);
    int e = (base + addr) & 255;
    if (mode == 1) return (e / 64) * 64 + (e % 64);
    return (e % 4) * 64 + (e / 4);
  endfunction

  // one access group; checks length, stall count, grant order and data
  task automatic run(int mode, logic [3:0] m, logic [3:0] w, int a[4], int bs[4],
                     logic [15:0] d[4], string tag);
    int bank[4], rank[4], got_cyc[4], maxg, cyc, p;
    logic [15:0] exp[4], got[4];
    logic [CW-1:0] cnt0;
    bit s;
    maxg = 0;
    for (int c = 0; c < 4; c++) begin
      p = phys(mode, bs[c], a[c]);
      bank[c] = p / 64;
      rank[c] = 0;
      for (int k = 0; k < c; k++) if (m[k] && bank[k] == bank[c]) rank[c]++;
      if (m[c]) begin
        if (rank[c] + 1 > maxg) maxg = rank[c] + 1;
        if (w[c]) ref_mem[p] = d[c]; else exp[c] = ref_mem[p];
      end
      got_cyc[c] = -1;
      got[c] = '0;
    end
    cnt0 = stall_cnt_o;
    mode_i = mode[0];
    req_i = m;
    we_i = w;
    for (int c = 0; c < 4; c++) begin
      addr_i[c*AW +: AW] = AW'(a[c]);
      base_i[c*AW +: AW] = AW'(bs[c]);
      wdata_i[c*DW +: DW] = d[c];
    end
    #1;
    cyc = 0;
    forever begin
      s = stall_o;
      @(posedge clk_i);
      @(negedge clk_i);
      cyc++;
      for (int c = 0; c < 4; c++)
        if (rvalid_o[c]) begin got_cyc[c] = cyc; got[c] = rdata_o[c*DW +: DW]; end
      if (!s || cyc > 20) break;
    end
    req_i = '0;
    we_i = '0;
    chk(cyc == maxg, tag, "group cycles", cyc, maxg);
    chk(stall_cnt_o - cnt0 == CW'(maxg - 1), tag, "stall count delta", int'(stall_cnt_o - cnt0), maxg - 1);
    for (int c = 0; c < 4; c++) begin
      if (m[c] && !w[c]) begin
        chk(got_cyc[c] == rank[c] + 1, tag, $sformatf("core%0d rvalid cycle", c), got_cyc[c], rank[c] + 1);
        chk(got[c] == exp[c], tag, $sformatf("core%0d rdata", c), got[c], exp[c]);
      end else if (m[c]) begin
        chk(got_cyc[c] == -1, {tag, " R9"}, $sformatf("core%0d rvalid on write", c), got_cyc[c], -1);
      end
    end
  endtask

  task automatic t_reset();
    chk(stall_o == 1'b0, "R1", "stall", stall_o, 0);
    chk(stall_cnt_o == '0, "R1", "stall count", stall_cnt_o, 0);
    chk(rvalid_o == '0, "R1", "rvalid", rvalid_o, 0);
    chk(rdata_o == '0, "R1", "rdata", 1, 0);
  endtask

  task automatic t_fill();
    int a[4], bs[4];
    logic [15:0] d[4];
    for (int g = 0; g < 64; g++) begin
      for (int c = 0; c < 4; c++) begin
        a[c] = 4*g + c; bs[c] = 0; d[c] = 16'hA000 ^ 16'((4*g + c) * 37);
      end
      run(0, 4'hF, 4'hF, a, bs, d, "R5");
    end
  endtask

  task automatic t_ilv_reads();
    int a[4] = '{5, 6, 7, 4}, bs[4] = '{0, 0, 0, 0};
    logic [15:0] d[4] = '{0, 0, 0, 0};
    run(0, 4'hF, 4'h0, a, bs, d, "R2 R5");
    a = '{0, 4, 8, 12};
    run(0, 4'hF, 4'h0, a, bs, d, "R6 R7");
    a = '{20, 9, 24, 13};
    run(0, 4'hF, 4'h0, a, bs, d, "R6");
  endtask

  task automatic t_seq_reads();
    int a[4] = '{0, 1, 2, 3}, bs[4] = '{0, 0, 0, 0};
    logic [15:0] d[4] = '{0, 0, 0, 0};
    run(1, 4'hF, 4'h0, a, bs, d, "R3 R6");
    a = '{65, 130, 195, 0};
    run(1, 4'hF, 4'h0, a, bs, d, "R3 R5");
  endtask

  task automatic t_base();
    int a[4] = '{0, 3, 1, 0}, bs[4] = '{3, 0, 1, 0};
    logic [15:0] d[4] = '{0, 0, 0, 0};
    run(0, 4'h7, 4'h0, a, bs, d, "R4");
    a = '{2, 0, 0, 0}; bs = '{254, 0, 0, 0};
    run(1, 4'h1, 4'h0, a, bs, d, "R4");
  endtask

  task automatic t_stride();
    int a[4] = '{0, 2, 4, 6}, bs[4] = '{0, 0, 0, 0};
    logic [15:0] d[4] = '{0, 0, 0, 0};
    run(0, 4'hF, 4'h0, a, bs, d, "R11");
    run(1, 4'hF, 4'h0, a, bs, d, "R3");
  endtask

  task automatic t_write_order();
    int a[4] = '{8, 0, 8, 8}, bs[4] = '{0, 0, 0, 0};
    logic [15:0] d[4] = '{16'h1234, 0, 0, 16'h5555};
    run(0, 4'hD, 4'h9, a, bs, d, "R9 R6");
    a = '{8, 0, 0, 0};
    run(0, 4'h1, 4'h0, a, bs, d, "R9");
  endtask

  task automatic t_hold();
    int a[4] = '{1, 2, 3, 4}, bs[4] = '{0, 0, 0, 0};
    logic [15:0] d[4] = '{16'h0F0F, 16'h0F0F, 16'h0F0F, 16'h0F0F};
    logic [NC*DW-1:0] snap;
    run(0, 4'hF, 4'h0, a, bs, d, "R8");
    snap = rdata_o;
    repeat (3) @(negedge clk_i);
    chk(rdata_o == snap, "R8", "rdata held idle", 0, 0);
    chk(rvalid_o == '0, "R8", "rvalid single pulse", rvalid_o, 0);
    a = '{100, 101, 102, 103};
    run(0, 4'hF, 4'hF, a, bs, d, "R9");
    @(negedge clk_i);
    chk(rdata_o == snap, "R8", "rdata held over writes", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fill();
    t_ilv_reads();
    t_seq_reads();
    t_base();
    t_stride();
    t_write_order();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule